// File: doc/BRIEF.md
# Byte-Bus Shadowed Up/Down Timer Counter

This block holds a 16-bit timer count that an 8-bit processor bus can read and write as one whole value. The count lives in a single register. The bus reaches it through two byte addresses and one 8-bit staging register that both addresses share. Software loads a count by writing the upper byte first, which only fills the staging register, and then the lower byte, which commits both bytes at once. Software reads a count by reading the lower byte first, which also freezes the upper byte into the staging register, and then reading the upper byte out of that register. The count can therefore never tear between the two byte accesses, even while it keeps running.

A mode controller outside the block supplies the direction and clear controls. A prescaler outside the block supplies a tick enable and a 3-bit source select. A select of zero halts counting, but the bus can still reach the count. The block has one operation decoder, built as a named-operation state selector, with six operations:

- HOLD: no change.
- LOAD: bus commit.
- CLEAR: set the count to zero.
- INC: add one.
- WRAP: return to zero after TOP, or after the all-ones value.
- DEC: subtract one.

Each clock picks exactly one of these operations, in a fixed priority order. The count register follows the chosen operation.

The block drives two compare flags that a neighbouring unit decodes: one for the count sitting at the programmable TOP value and one for the count sitting at zero. It also keeps a sticky overflow request bit, which software clears through a flag address.

Top module: `bus_shadow_counter`

## Requirements
- R1: After reset the count and the staging register are zero, the overflow request is low, and the zero flag is high.
- R2: A write to address 1 loads only the staging register. The count does not change, and a later read of address 1 returns the written byte.
- R3: A read of address 0 returns the count's lower byte combinationally. On that clock edge the count's upper byte, as it was before the edge, is copied into the staging register. A read of address 1 returns the staging register.
- R4: A write to address 0 loads the count with the staging register as bits 15:8 and the bus byte as bits 7:0, in one clock.
- R5: On an active tick with clear low and direction low (up), the count increments. If the count equals TOP or 0xFFFF, it becomes 0 instead.
- R6: On an active tick with clear low and direction high (down), the count decrements, and 0 becomes 0xFFFF.
- R7: On an active tick with clear high, the count becomes 0 whatever the direction.
- R8: A tick is active only when the tick enable is high and the source select is nonzero. With a select of 0 the count holds, while bus reads and writes still work.
- R9: A write to address 0 overrides any clear, increment or decrement in the same clock.
- R10: The TOP flag is high exactly when the count equals the TOP input. The zero flag is high exactly when the count is 0.
- R11: An up tick taken from 0xFFFF sets the overflow request. The request stays set until a bus write to address 2 with data bit 0 equal to 1. A write there with bit 0 equal to 0 has no effect. A set event in the same clock as a clearing write wins.
- R12: A read of address 2 returns the overflow request in bit 0 and zeros above it. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable from the prescaler |
| clk_sel | input | 3 | Source select; zero halts counting |
| count_down | input | 1 | Direction: 1 counts down |
| count_clear | input | 1 | Clear the count on the next active tick |
| top_value | input | 16 | Programmable TOP value |
| bus_addr | input | 2 | Byte address: 0 lower, 1 upper (staging), 2 flag |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, valid while bus_rd is high |
| cnt_value | output | 16 | Current count for neighbouring units |
| at_top | output | 1 | Count equals top_value |
| at_bottom | output | 1 | Count equals zero |
| ovf_irq | output | 1 | Sticky overflow request |

## Verification
The bench first goes after read atomicity. It snapshots 0x12FF and then lets the count roll to 0x1300 before reading the upper byte. A design that copied the upper byte at the wrong moment, or read it live, would return 0x13.

It then drives a lower-byte write in the same clock as an active clear or count. A design with the priority reversed would show zero or a stepped value instead of the loaded one.

At the count edges it checks the down step from 0 and the up wrap at a small TOP. A design that got these wrong would land on the wrong value or raise overflow from TOP. It also checks the overflow set in the same clock as a clearing write, which a design that lets the clear win would drop.

A halted select with the tick enable still high checks that a design gating on the enable alone would keep counting.

// File: rtl/bsc_pkg.sv
`timescale 1ns/1ps
package bsc_pkg;

    // Operation applied to the count register on the coming edge
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_LOAD,
        OP_CLEAR,
        OP_INC,
        OP_WRAP,
        OP_DEC
    } cnt_op_e;

    // Which byte location the current bus cycle targets
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LO,
        SEL_HI,
        SEL_FLAG
    } bus_sel_e;

endpackage

// File: rtl/bsc_bus_decode.sv
`timescale 1ns/1ps
module bsc_bus_decode
    import bsc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_LO   = 0,
    parameter int unsigned ADDR_HI   = 1,
    parameter int unsigned ADDR_FLAG = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_lo,
    input  logic [DATA_W-1:0] temp_q,
    input  logic              ovf_q,
    output logic              lo_wr,
    output logic              lo_rd,
    output logic              hi_wr,
    output logic              flag_clr,
    output logic [DATA_W-1:0] bus_rdata
);

    bus_sel_e sel;

    always_comb begin
        if (bus_addr == ADDR_W'(ADDR_LO)) begin
            sel = SEL_LO;
        end else if (bus_addr == ADDR_W'(ADDR_HI)) begin
            sel = SEL_HI;
        end else if (bus_addr == ADDR_W'(ADDR_FLAG)) begin
            sel = SEL_FLAG;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        lo_wr     = 1'b0;
        lo_rd     = 1'b0;
        hi_wr     = 1'b0;
        flag_clr  = 1'b0;
        bus_rdata = '0;
        unique case (sel)
            SEL_LO: begin
                lo_wr = bus_wr;
                lo_rd = bus_rd;
                if (bus_rd) bus_rdata = cnt_lo;
            end
            SEL_HI: begin
                hi_wr = bus_wr;
                if (bus_rd) bus_rdata = temp_q;
            end
            SEL_FLAG: begin
                flag_clr = bus_wr & bus_wdata[0];
                if (bus_rd) bus_rdata = DATA_W'(ovf_q);
            end
            SEL_NONE: begin
                bus_rdata = '0;
            end
        endcase
    end

endmodule

// File: rtl/bsc_temp_reg.sv
`timescale 1ns/1ps
module bsc_temp_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic              lo_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cnt_hi,
    output logic [DATA_W-1:0] temp_q
);

    logic [DATA_W-1:0] temp_d;

    always_comb begin
        temp_d = temp_q;
        if (hi_wr) begin
            temp_d = wdata;
        end else if (lo_rd) begin
            temp_d = cnt_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) temp_q <= '0;
        else        temp_q <= temp_d;
    end

endmodule

// File: rtl/bsc_count_core.sv
`timescale 1ns/1ps
module bsc_count_core
    import bsc_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              count_down,
    input  logic              count_clear,
    input  logic [CNT_W-1:0]  top_value,
    input  logic              lo_wr,
    input  logic [CNT_W-1:0]  load_value,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf_event,
    output logic              at_top,
    output logic              at_bottom
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cnt_op_e          op;
    logic             tick_live;
    logic [CNT_W-1:0] cnt_d;

    assign tick_live = tick_en && (clk_sel != '0);

    // Operation selection in priority order
    always_comb begin
        if (lo_wr) begin
            op = OP_LOAD;
        end else if (!tick_live) begin
            op = OP_HOLD;
        end else if (count_clear) begin
            op = OP_CLEAR;
        end else if (count_down) begin
            op = OP_DEC;
        end else if ((cnt_q == top_value) || (cnt_q == CNT_MAX)) begin
            op = OP_WRAP;
        end else begin
            op = OP_INC;
        end
    end

    always_comb begin
        unique case (op)
            OP_HOLD:  cnt_d = cnt_q;
            OP_LOAD:  cnt_d = load_value;
            OP_CLEAR: cnt_d = '0;
            OP_INC:   cnt_d = cnt_q + 1'b1;
            OP_WRAP:  cnt_d = '0;
            OP_DEC:   cnt_d = cnt_q - 1'b1;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ovf_event = (op == OP_WRAP) && (cnt_q == CNT_MAX);
    assign at_top    = (cnt_q == top_value);
    assign at_bottom = (cnt_q == '0);

endmodule

// File: rtl/bsc_ovf_flag.sv
`timescale 1ns/1ps
module bsc_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic ovf_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (set_evt) ovf_q <= 1'b1;
        else if (clr_req) ovf_q <= 1'b0;
    end

endmodule

// File: rtl/bus_shadow_counter.sv
`timescale 1ns/1ps
module bus_shadow_counter #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned CSEL_W    = 3,
    parameter int unsigned ADDR_LO   = 0,
    parameter int unsigned ADDR_HI   = 1,
    parameter int unsigned ADDR_FLAG = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [CSEL_W-1:0]   clk_sel,
    input  logic                count_down,
    input  logic                count_clear,
    input  logic [2*DATA_W-1:0] top_value,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [2*DATA_W-1:0] cnt_value,
    output logic                at_top,
    output logic                at_bottom,
    output logic                ovf_irq
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic              lo_wr;
    logic              lo_rd;
    logic              hi_wr;
    logic              flag_clr;
    logic              ovf_event;
    logic [DATA_W-1:0] temp_q;
    logic [CNT_W-1:0]  cnt_q;

    bsc_bus_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ADDR_LO   (ADDR_LO),
        .ADDR_HI   (ADDR_HI),
        .ADDR_FLAG (ADDR_FLAG)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .cnt_lo    (cnt_q[DATA_W-1:0]),
        .temp_q    (temp_q),
        .ovf_q     (ovf_irq),
        .lo_wr     (lo_wr),
        .lo_rd     (lo_rd),
        .hi_wr     (hi_wr),
        .flag_clr  (flag_clr),
        .bus_rdata (bus_rdata)
    );

    bsc_temp_reg #(
        .DATA_W (DATA_W)
    ) u_temp (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_wr  (hi_wr),
        .lo_rd  (lo_rd),
        .wdata  (bus_wdata),
        .cnt_hi (cnt_q[CNT_W-1:DATA_W]),
        .temp_q (temp_q)
    );

    bsc_count_core #(
        .CNT_W  (CNT_W),
        .CSEL_W (CSEL_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .clk_sel     (clk_sel),
        .count_down  (count_down),
        .count_clear (count_clear),
        .top_value   (top_value),
        .lo_wr       (lo_wr),
        .load_value  ({temp_q, bus_wdata}),
        .cnt_q       (cnt_q),
        .ovf_event   (ovf_event),
        .at_top      (at_top),
        .at_bottom   (at_bottom)
    );

    bsc_ovf_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ovf_event),
        .clr_req (flag_clr),
        .ovf_q   (ovf_irq)
    );

    assign cnt_value = cnt_q;

endmodule

// File: rtl/bsc_checker.sv
`timescale 1ns/1ps
module bsc_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned CSEL_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_en,
    input logic [CSEL_W-1:0]   clk_sel,
    input logic                count_down,
    input logic                count_clear,
    input logic [2*DATA_W-1:0] top_value,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [2*DATA_W-1:0] cnt_value,
    input logic [DATA_W-1:0]   temp_q,
    input logic                ovf_irq
);

    localparam int unsigned CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ticking;
    logic lo_write;
    logic lo_read;
    assign ticking  = tick_en && (clk_sel != '0);
    assign lo_write = bus_wr && (bus_addr == '0);
    assign lo_read  = bus_rd && (bus_addr == '0);

    AST_LOAD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        lo_write |=> cnt_value == {$past(temp_q), $past(bus_wdata)}); // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ticking && !lo_write) |=> $stable(cnt_value)); // R8

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ticking && !lo_write && !count_clear && !count_down
         && cnt_value != top_value && cnt_value != CNT_MAX)
        |=> cnt_value == CNT_W'($past(cnt_value) + 1)); // R5

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ticking && !lo_write && !count_clear && count_down)
        |=> cnt_value == CNT_W'($past(cnt_value) - 1)); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ticking && !lo_write && count_clear) |=> cnt_value == '0); // R7

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_read && !bus_wr) |=> temp_q == $past(cnt_value[CNT_W-1:DATA_W])); // R3

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ticking && !lo_write && !count_clear && !count_down && cnt_value == CNT_MAX)
        |=> ovf_irq); // R11

    AST_HI_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1) |-> bus_rdata == temp_q); // R3

endmodule

bind bus_shadow_counter bsc_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CSEL_W (CSEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .clk_sel     (clk_sel),
    .count_down  (count_down),
    .count_clear (count_clear),
    .top_value   (top_value),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cnt_value   (cnt_value),
    .temp_q      (temp_q),
    .ovf_irq     (ovf_irq)
);

// File: tb/bus_shadow_counter_bench.sv
`timescale 1ns/1ps
module bus_shadow_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [2:0]  clk_sel = '0;
    logic        count_down = 1'b0;
    logic        count_clear = 1'b0;
    logic [15:0] top_value = 16'hFFFF;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cnt_value;
    logic        at_top;
    logic        at_bottom;
    logic        ovf_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [15:0] m_cnt  = '0;
    logic [7:0]  m_temp = '0;
    logic        m_ovf  = 1'b0;

    always #10 clk = ~clk;

    bus_shadow_counter u_bus_shadow_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .clk_sel     (clk_sel),
        .count_down  (count_down),
        .count_clear (count_clear),
        .top_value   (top_value),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_value   (cnt_value),
        .at_top      (at_top),
        .at_bottom   (at_bottom),
        .ovf_irq     (ovf_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected next count from the requirements
    function automatic logic [15:0] exp_next(input logic [15:0] c, input logic [15:0] top,
            input logic tk, input logic clr, input logic dn, input logic ldw,
            input logic [15:0] ldv);
        if (ldw)       return ldv;
        if (!tk)       return c;
        if (clr)       return 16'h0000;
        if (dn)        return c - 16'd1;
        if (c == top || c == 16'hFFFF) return 16'h0000;
        return c + 16'd1;
    endfunction

    function automatic string cnt_tag(input logic tk, input logic clr, input logic dn,
            input logic ldw, input logic hwr);
        if (ldw) return tk ? "R9" : "R4";
        if (!tk) return hwr ? "R2" : "R8";
        if (clr) return "R7";
        if (dn)  return "R6";
        return "R5";
    endfunction

    task automatic apply(input logic te, input logic [2:0] cs, input logic dn, input logic clr,
            input logic [15:0] top, input logic [1:0] addr, input logic wr, input logic rd,
            input logic [7:0] wd);
        logic tk, ldw, lrd, hwr, fclr, oset;
        logic [7:0] exp_rd;
        @(negedge clk);
        tick_en = te; clk_sel = cs; count_down = dn; count_clear = clr;
        top_value = top; bus_addr = addr; bus_wr = wr; bus_rd = rd; bus_wdata = wd;
        #1;
        if (rd) begin
            case (addr)
                2'd0:    exp_rd = m_cnt[7:0];
                2'd1:    exp_rd = m_temp;
                2'd2:    exp_rd = {7'd0, m_ovf};
                default: exp_rd = 8'h00;
            endcase
            chk(addr == 2'd0 ? "R3" : addr == 2'd1 ? "R3" : "R12", 16'(bus_rdata), 16'(exp_rd));
        end
        tk   = te && (cs != 3'd0);
        ldw  = wr && addr == 2'd0;
        lrd  = rd && addr == 2'd0;
        hwr  = wr && addr == 2'd1;
        fclr = wr && addr == 2'd2 && wd[0];
        oset = !ldw && tk && !clr && !dn && m_cnt == 16'hFFFF;
        @(posedge clk);
        #1;
        m_cnt  = exp_next(m_cnt, top, tk, clr, dn, ldw, {m_temp, wd});
        m_temp = hwr ? wd : lrd ? m_cnt[15:8] : m_temp;
        if (lrd && !hwr) m_temp = cnt_value_before;
        m_ovf  = oset ? 1'b1 : fclr ? 1'b0 : m_ovf;
        chk(cnt_tag(tk, clr, dn, ldw, hwr), cnt_value, m_cnt);
        chk("R10", {14'd0, at_top, at_bottom}, {14'd0, m_cnt == top, m_cnt == 16'd0});
        chk("R11", 16'(ovf_irq), 16'(m_ovf));
    endtask

    // Upper byte of the model count before the edge, kept for the snapshot
    logic [7:0] cnt_value_before;
    always @(negedge clk) cnt_value_before = m_cnt[15:8];

    task automatic bus_write(input logic [1:0] addr, input logic [7:0] d);
        apply(1'b0, 3'd0, 1'b0, 1'b0, top_value, addr, 1'b1, 1'b0, d);
    endtask

    task automatic bus_read(input logic [1:0] addr);
        apply(1'b0, 3'd0, 1'b0, 1'b0, top_value, addr, 1'b0, 1'b1, 8'h00);
    endtask

    task automatic load16(input logic [15:0] v);
        bus_write(2'd1, v[15:8]);
        bus_write(2'd0, v[7:0]);
    endtask

    task automatic tick_up(input logic [15:0] top);
        apply(1'b1, 3'd1, 1'b0, 1'b0, top, 2'd3, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", cnt_value, 16'h0000);
        chk("R1", {15'd0, at_bottom}, 16'd1);
        chk("R1", 16'(ovf_irq), 16'd0);
        bus_read(2'd1);                                   // R1 staging zero

        // R2 then R4: staged upper byte, commit on lower write
        bus_write(2'd1, 8'hAB);
        bus_read(2'd1);
        bus_write(2'd0, 8'hCD);
        chk("R4", cnt_value, 16'hABCD);

        // R3: snapshot survives a carry into the upper byte
        load16(16'h12FF);
        bus_read(2'd0);
        tick_up(16'hFFFF);
        chk("R5", cnt_value, 16'h1300);
        bus_read(2'd1);                                   // expects 12

        // R9: load beats clear and count
        bus_write(2'd1, 8'h55);
        apply(1'b1, 3'd2, 1'b0, 1'b1, 16'hFFFF, 2'd0, 1'b1, 1'b0, 8'h66);
        chk("R9", cnt_value, 16'h5566);
        apply(1'b1, 3'd2, 1'b1, 1'b0, 16'hFFFF, 2'd0, 1'b1, 1'b0, 8'h77);

        // R8: halted select ignores tick enable, bus still works
        for (int i = 0; i < 4; i++)
            apply(1'b1, 3'd0, 1'b0, 1'b0, 16'hFFFF, 2'd0, 1'b0, 1'b1, 8'h00);
        chk("R8", cnt_value, 16'h5577);

        // R6: down from zero
        load16(16'h0000);
        apply(1'b1, 3'd5, 1'b1, 1'b0, 16'hFFFF, 2'd3, 1'b0, 1'b0, 8'h00);
        chk("R6", cnt_value, 16'hFFFF);

        // R7: clear while counting down
        apply(1'b1, 3'd7, 1'b1, 1'b1, 16'hFFFF, 2'd3, 1'b0, 1'b0, 8'h00);
        chk("R7", cnt_value, 16'h0000);

        // R5, R11: wrap from all-ones sets sticky request
        load16(16'hFFFE);
        tick_up(16'hFFFF);
        tick_up(16'hFFFF);
        chk("R11", 16'(ovf_irq), 16'd1);
        bus_read(2'd2);
        bus_write(2'd2, 8'hFE);                           // bit 0 clear: no effect
        chk("R11", 16'(ovf_irq), 16'd1);
        bus_write(2'd2, 8'h01);
        chk("R11", 16'(ovf_irq), 16'd0);
        bus_read(2'd3);                                   // R12 unused address
        load16(16'hFFFF);
        apply(1'b1, 3'd1, 1'b0, 1'b0, 16'hFFFF, 2'd2, 1'b1, 1'b0, 8'h01);
        chk("R11", 16'(ovf_irq), 16'd1);
        bus_write(2'd2, 8'h01);

        // R5, R10: small TOP wraps without overflow
        load16(16'h0003);
        for (int i = 0; i < 4; i++) tick_up(16'h0005);
        chk("R5", cnt_value, 16'h0001);
        chk("R11", 16'(ovf_irq), 16'd0);

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] top;
            logic [1:0]  a;
            logic        w, r;
            top = ($urandom % 4 == 0) ? 16'($urandom % 16) : 16'hFFFF;
            if ($urandom % 64 == 0) begin
                load16(($urandom % 2) ? 16'hFFF8 : 16'($urandom));
            end
            a = 2'($urandom);
            w = ($urandom % 6 == 0);
            r = !w && ($urandom % 3 == 0);
            apply(($urandom % 4) != 0, 3'($urandom), ($urandom % 4 == 0),
                  ($urandom % 20 == 0), top, a, w, r, 8'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule